// File: doc/BRIEF.md
# Access Violation Error Capture Unit

This block sits next to a memory region checker and keeps one capture channel for each slave port. When the checker denies an access on a port, the channel records the full address and a detail word on the next clock edge. It also raises a sticky per-port error flag. The detail word holds the requester's master number, its privilege level, whether it was an instruction fetch, whether it was a write, its process identifier, and the mask of every region descriptor the access matched. From that mask software can tell three cases apart: no match, a single match, or overlapping matches.

Software reads the capture registers through a simple word-addressed register port. It then acknowledges the error by writing one to the flag in the shared status word. The status word also carries fixed build information: the revision level, the port count and the descriptor count. The permission decision, interrupts and bus error responses belong to other blocks.

Top module: `viol_capture`

## Requirements
- R1: After reset every flag is clear, and every address and detail register reads zero.
- R2: A deny on port n is captured at the next rising clock edge. From then on the status word shows bit (NUM_PORTS-1-n) set, and the port's address register (word 1+2n) holds the denied address.
- R3: The port's detail register (word 2+2n) holds:
  - bit 0: write
  - bit 1: instruction fetch
  - bit 2: supervisor
  - bit 3: zero
  - bits [7:4]: master number
  - bits [15:8]: process identifier
  - bits [31:16]: region-hit mask, one bit per descriptor
- R4: While a port's flag is set, further denies on that port leave its address and detail registers unchanged.
- R5: A write to word 0 clears each port flag whose slot bit in the write data is one. Slots written with zero keep their flags.
- R6: If a deny and a clearing write reach the same port in the same cycle, the flag stays set and the new access is captured.
- R7: The status word reads as follows:
  - bits [11:8]: HW_REV
  - bits [15:12]: NUM_PORTS
  - bits [23:16]: NUM_DESC
  - all other bits outside the flag field: zero
  No write changes these fields.
- R8: Ports are independent: denies on several ports in one cycle are all captured, and clearing one flag leaves the others.
- R9: Writes to address or detail words are ignored. Reads of word indices above 2*NUM_PORTS return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| viol_valid | input | NUM_PORTS | Per-port deny strobe from the region checker |
| viol_addr | input | NUM_PORTS*ADDR_W | Per-port access address |
| viol_hits | input | NUM_PORTS*NUM_DESC | Per-port descriptor hit mask |
| viol_master | input | NUM_PORTS*MASTER_W | Per-port requesting master number |
| viol_pid | input | NUM_PORTS*PID_W | Per-port process identifier |
| viol_super | input | NUM_PORTS | Per-port supervisor attribute |
| viol_fetch | input | NUM_PORTS | Per-port instruction-fetch attribute |
| viol_write | input | NUM_PORTS | Per-port write (1) or read (0) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | NUM_PORTS | Write data for the status flag field |
| reg_rdata | output | 32 | Combinational read data |

## Verification
A wrong flag shows in the status word at the first falling edge after the offending clock edge, because reads are combinational. A lost or overwritten capture shows as a stale or wrong value in the port's address or detail word in that same cycle. A reversed or shifted slot mapping shows as a flag in the wrong bit position. It also shows as a clearing write that hits the wrong port, which becomes visible one cycle later. The sweep walks every port through no-match, every single-descriptor hit and an overlapping hit, so any error in packing a field appears as soon as that capture is read back.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int REG_W      = 32;
  localparam int MAX_PORTS  = 8;
  localparam int MAX_DESC   = 16;

  // detail word: hits[31:16] pid[15:8] master[7:4] 0[3] sup[2] fetch[1] wr[0]
  function automatic logic [31:0] pack_detail(input logic [15:0] hits,
                                              input logic [7:0]  pid,
                                              input logic [3:0]  master,
                                              input logic        sup,
                                              input logic        fetch,
                                              input logic        wr);
    return {hits, pid, master, 1'b0, sup, fetch, wr};
  endfunction

  // status word: 0[31:24] ndesc[23:16] nports[15:12] rev[11:8] flags[7:0]
  function automatic logic [31:0] pack_status(input logic [7:0] flags,
                                              input logic [3:0] rev,
                                              input logic [3:0] nports,
                                              input logic [7:0] ndesc);
    return {8'h00, ndesc, nports, rev, flags};
  endfunction

  // port n lives at reversed slot inside the flag field
  function automatic int flag_slot(input int np, input int port);
    return np - 1 - port;
  endfunction
endpackage

// File: rtl/vc_channel.sv
module vc_channel #(
  parameter int ADDR_W = 32,
  parameter int DET_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DET_W-1:0]  detail_i,
  output logic              flag_o,
  output logic              cap_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DET_W-1:0]  detail_o
);
  logic              flag_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DET_W-1:0]  det_q;
  logic              take;

  // capture when idle, or when the same cycle's clear frees the slot
  assign take = deny_i && (!flag_q || clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      det_q  <= '0;
    end else begin
      if (deny_i)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      if (take) begin
        addr_q <= addr_i;
        det_q  <= detail_i;
      end
    end
  end

  assign flag_o   = flag_q;
  assign cap_o    = take;
  assign addr_o   = addr_q;
  assign detail_o = det_q;
endmodule

// File: rtl/vc_status.sv
module vc_status #(
  parameter int       NUM_PORTS = 4,
  parameter int       NUM_DESC  = 8,
  parameter bit [3:0] HW_REV    = 4'd2
) (
  input  logic [NUM_PORTS-1:0] flags_i,
  output logic [31:0]          status_o
);
  localparam int FIELD_W = vc_pkg::MAX_PORTS;

  logic [FIELD_W-1:0] field;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
    localparam int SLOT = vc_pkg::flag_slot(NUM_PORTS, p);
    assign field[SLOT] = flags_i[p];
  end
  if (NUM_PORTS < FIELD_W) begin : g_pad
    assign field[FIELD_W-1:NUM_PORTS] = '0;
  end

  assign status_o = vc_pkg::pack_status(field, HW_REV, 4'(NUM_PORTS), 8'(NUM_DESC));
endmodule

// File: rtl/vc_readmux.sv
module vc_readmux #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 32,
  parameter int RA_W      = 4
) (
  input  logic [RA_W-1:0]             reg_addr,
  input  logic [31:0]                 status_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] addrs_i,
  input  logic [NUM_PORTS*32-1:0]     details_i,
  output logic [31:0]                 rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (reg_addr == '0) rdata_o = status_i;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (reg_addr == RA_W'(2*p + 1)) rdata_o = 32'(addrs_i[p*ADDR_W +: ADDR_W]);
      if (reg_addr == RA_W'(2*p + 2)) rdata_o = details_i[p*32 +: 32];
    end
  end
endmodule

// File: rtl/viol_capture.sv
module viol_capture #(
  parameter int       NUM_PORTS = 4,
  parameter int       NUM_DESC  = 8,
  parameter int       ADDR_W    = 32,
  parameter int       MASTER_W  = 3,
  parameter int       PID_W     = 8,
  parameter bit [3:0] HW_REV    = 4'd2,
  localparam int      RA_W      = $clog2(2*NUM_PORTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        viol_valid,
  input  logic [NUM_PORTS*ADDR_W-1:0] viol_addr,
  input  logic [NUM_PORTS*NUM_DESC-1:0] viol_hits,
  input  logic [NUM_PORTS*MASTER_W-1:0] viol_master,
  input  logic [NUM_PORTS*PID_W-1:0]  viol_pid,
  input  logic [NUM_PORTS-1:0]        viol_super,
  input  logic [NUM_PORTS-1:0]        viol_fetch,
  input  logic [NUM_PORTS-1:0]        viol_write,
  input  logic                        reg_wr_en,
  input  logic [RA_W-1:0]             reg_addr,
  input  logic [NUM_PORTS-1:0]        reg_wdata,
  output logic [31:0]                 reg_rdata
);
  localparam int DET_W = vc_pkg::REG_W;

  // named internal events for the checker
  logic [NUM_PORTS-1:0]        flag_vec;
  logic [NUM_PORTS-1:0]        cap_evt;
  logic [NUM_PORTS-1:0]        clr_evt;
  logic [NUM_PORTS*ADDR_W-1:0] addr_cap;
  logic [NUM_PORTS*DET_W-1:0]  det_cap;
  logic [31:0]                 status_word;
  logic                        status_wr;

  assign status_wr = reg_wr_en && (reg_addr == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int SLOT = vc_pkg::flag_slot(NUM_PORTS, p);
    logic [DET_W-1:0] det_in;

    assign clr_evt[p] = status_wr && reg_wdata[SLOT];
    assign det_in = vc_pkg::pack_detail(16'(viol_hits[p*NUM_DESC +: NUM_DESC]),
                                        8'(viol_pid[p*PID_W +: PID_W]),
                                        4'(viol_master[p*MASTER_W +: MASTER_W]),
                                        viol_super[p], viol_fetch[p], viol_write[p]);

    vc_channel #(.ADDR_W(ADDR_W), .DET_W(DET_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .deny_i   (viol_valid[p]),
      .clr_i    (clr_evt[p]),
      .addr_i   (viol_addr[p*ADDR_W +: ADDR_W]),
      .detail_i (det_in),
      .flag_o   (flag_vec[p]),
      .cap_o    (cap_evt[p]),
      .addr_o   (addr_cap[p*ADDR_W +: ADDR_W]),
      .detail_o (det_cap[p*DET_W +: DET_W])
    );
  end

  vc_status #(.NUM_PORTS(NUM_PORTS), .NUM_DESC(NUM_DESC), .HW_REV(HW_REV)) u_status (
    .flags_i  (flag_vec),
    .status_o (status_word)
  );

  vc_readmux #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .RA_W(RA_W)) u_rd (
    .reg_addr  (reg_addr),
    .status_i  (status_word),
    .addrs_i   (addr_cap),
    .details_i (det_cap),
    .rdata_o   (reg_rdata)
  );
endmodule

// File: rtl/viol_capture_chk.sv
module viol_capture_chk #(
  parameter int NP = 4,
  parameter int AW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NP-1:0]  deny,
  input logic [NP-1:0]  flags,
  input logic [NP-1:0]  clr_evt,
  input logic [NP-1:0]  cap_evt,
  input logic [NP*AW-1:0] addr_in,
  input logic [NP*AW-1:0] addr_cap,
  input logic [31:0]    status
);
  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R2
    set_after_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deny[p] |=> flags[p]);
    // R2
    status_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[NP-1-p] == flags[p]);
    // R4
    hold_while_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[p] && !clr_evt[p] |=> $stable(addr_cap[p*AW +: AW]));
    // R4
    no_capture_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[p] && !clr_evt[p] |-> !cap_evt[p]);
    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[p] && clr_evt[p] && !deny[p] |=> !flags[p]);
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[p] && clr_evt[p] && deny[p] |=>
        flags[p] && addr_cap[p*AW +: AW] == $past(addr_in[p*AW +: AW]));
  end
endmodule

bind viol_capture viol_capture_chk #(.NP(NUM_PORTS), .AW(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .deny     (viol_valid),
  .flags    (flag_vec),
  .clr_evt  (clr_evt),
  .cap_evt  (cap_evt),
  .addr_in  (viol_addr),
  .addr_cap (addr_cap),
  .status   (status_word)
);

// File: tb/tb_viol_capture.sv
`timescale 1ns/1ps
module tb_viol_capture;
  localparam int NP = 4, ND = 8, AW = 32, MW = 3, PW = 8;
  localparam int RA_W = $clog2(2*NP + 1);
  localparam logic [31:0] INFO = (32'(ND) << 16) | (32'(NP) << 12) | (32'd2 << 8);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    v_valid = '0;
  logic [NP*AW-1:0] v_addr = '0;
  logic [NP*ND-1:0] v_hits = '0;
  logic [NP*MW-1:0] v_master = '0;
  logic [NP*PW-1:0] v_pid = '0;
  logic [NP-1:0]    v_sup = '0, v_fetch = '0, v_wr = '0;
  logic             reg_wr_en = 1'b0;
  logic [RA_W-1:0]  reg_addr = '0;
  logic [NP-1:0]    reg_wdata = '0;
  logic [31:0]      reg_rdata;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  viol_capture dut (
    .clk(clk), .rst_n(rst_n), .viol_valid(v_valid), .viol_addr(v_addr),
    .viol_hits(v_hits), .viol_master(v_master), .viol_pid(v_pid),
    .viol_super(v_sup), .viol_fetch(v_fetch), .viol_write(v_wr),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = RA_W'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [NP-1:0] d);
    reg_wr_en = 1'b1; reg_addr = RA_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic load(input int p, input logic [31:0] a, input logic [7:0] h,
                      input logic [2:0] m, input logic s, input logic f,
                      input logic w, input logic [7:0] pid);
    v_valid[p] = 1'b1; v_addr[p*AW +: AW] = a; v_hits[p*ND +: ND] = h;
    v_master[p*MW +: MW] = m; v_pid[p*PW +: PW] = pid;
    v_sup[p] = s; v_fetch[p] = f; v_wr[p] = w;
  endtask

  task automatic fire(input int p, input logic [31:0] a, input logic [7:0] h,
                      input logic [2:0] m, input logic s, input logic f,
                      input logic w, input logic [7:0] pid);
    load(p, a, h, m, s, f, w, pid);
    @(negedge clk);
    v_valid = '0;
  endtask

  function automatic logic [31:0] exp_det(input logic [7:0] h, input logic [7:0] pid,
                                          input logic [2:0] m, input logic s,
                                          input logic f, input logic w);
    return 32'(h) * 65536 + 32'(pid) * 256 + 32'(m) * 16 + 32'(s) * 4 + 32'(f) * 2 + 32'(w);
  endfunction

  function automatic logic [31:0] slot(input int p);
    return 32'(1) << (NP - 1 - p);
  endfunction

  initial begin
    #(200000 * 20);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] h;
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, d); chk("R1 status", d, INFO);
    for (int w = 1; w <= 2*NP; w++) begin rd(w, d); chk("R1 capture reg", d, 0); end

    // R2 R3 R5 sweep: every port, miss / each single hit / overlap
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 10; k++) begin
        h = (k == 0) ? 8'h00 : (k <= 8) ? 8'(1 << (k-1)) : 8'hC3;
        a = 32'h1000_0000 + 32'(p) * 32'h0010_0000 + 32'(k) * 32'h44 + 32'd3;
        fire(p, a, h, 3'((p + k) % 8), k[0], k[1], k[2] ^ p[0], 8'(p*16 + k + 1));
        rd(0, d);       chk("R2 flag slot", d, INFO | slot(p));
        rd(1 + 2*p, d); chk("R2 address", d, a);
        rd(2 + 2*p, d); chk("R3 detail", d, exp_det(h, 8'(p*16 + k + 1), 3'((p + k) % 8), k[0], k[1], k[2] ^ p[0]));
        wr(0, NP'(slot(p)));
        rd(0, d);       chk("R5 cleared", d, INFO);
      end
    end

    // R4 second deny while set is not recorded
    fire(1, 32'hAAAA_0000, 8'h01, 3'd1, 1'b0, 1'b0, 1'b1, 8'h11);
    fire(1, 32'hBBBB_0000, 8'h06, 3'd5, 1'b1, 1'b1, 1'b0, 8'h22);
    rd(3, d); chk("R4 address held", d, 32'hAAAA_0000);
    rd(4, d); chk("R4 detail held", d, exp_det(8'h01, 8'h11, 3'd1, 1'b0, 1'b0, 1'b1));
    rd(0, d); chk("R4 flag still set", d, INFO | slot(1));

    // R5 writing zero, or ones to other slots, keeps the flag
    wr(0, '0);
    rd(0, d); chk("R5 zero write", d, INFO | slot(1));
    wr(0, NP'(slot(0) | slot(2) | slot(3)));
    rd(0, d); chk("R5 other slots", d, INFO | slot(1));

    // R6 deny and clear together on a set port
    load(1, 32'hCCCC_0040, 8'h30, 3'd6, 1'b1, 1'b0, 1'b1, 8'h33);
    wr(0, NP'(slot(1)));
    v_valid = '0;
    rd(0, d); chk("R6 flag kept", d, INFO | slot(1));
    rd(3, d); chk("R6 new address", d, 32'hCCCC_0040);
    rd(4, d); chk("R6 new detail", d, exp_det(8'h30, 8'h33, 3'd6, 1'b1, 1'b0, 1'b1));

    // R8 simultaneous denies, selective clear
    load(0, 32'h0000_1230, 8'h80, 3'd2, 1'b0, 1'b1, 1'b0, 8'h44);
    load(3, 32'h0000_7890, 8'h00, 3'd7, 1'b1, 1'b1, 1'b1, 8'h55);
    @(negedge clk); v_valid = '0;
    rd(0, d); chk("R8 both set", d, INFO | slot(0) | slot(1) | slot(3));
    rd(1, d); chk("R8 port0 address", d, 32'h0000_1230);
    rd(7, d); chk("R8 port3 address", d, 32'h0000_7890);
    wr(0, NP'(slot(0)));
    rd(0, d); chk("R8 port0 only cleared", d, INFO | slot(1) | slot(3));

    // R7 all-ones write clears flags but not info
    wr(0, '1);
    rd(0, d); chk("R7 info fields", d, INFO);

    // R9 writes to capture words ignored, unmapped reads zero
    rd(5, d); a = d;
    wr(5, '1);
    rd(5, d); chk("R9 address write ignored", d, a);
    rd(0, d); chk("R9 no flag from write", d, INFO);
    for (int w = 2*NP + 1; w < (1 << RA_W); w++) begin rd(w, d); chk("R9 unmapped", d, 0); end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule